// File: doc/BRIEF.md
# Request-Triggered Descriptor Move Engine

The engine watches one external request pin and holds each accepted request in a pending flag. A select bit in the channel descriptor decides what that pending request does. With the bit clear, the engine raises an ordinary interrupt and waits for software to acknowledge it. With the bit set, the engine moves one data item between a peripheral register in the lowest 256 bytes of the address space and a memory buffer. It then advances the descriptor and drops the pending flag with a one-cycle clear pulse, so the pin can request again.

Software fills the descriptor through a load port while the engine is idle. The descriptor holds an 8-bit peripheral pointer, a buffer pointer, an item count, a direction and the select bit. When the count runs out, the engine turns the select bit off and raises an end-of-transfer interrupt. Any later request then arrives as a plain interrupt. The bus has a single master, and every read or write strobe lasts exactly one cycle.

Top module: `desc_xfer_engine`

## Requirements
- R1: After a synchronous reset, irq_out, eot_irq, bus_rd, bus_wr, clr_pulse and desc_sel are all 0.
- R2: With level_mode=0, a rising edge on req_in sets the pending flag. Further edges that arrive while the flag is set are ignored. After int_ack clears the flag, those edges cause no interrupt.
- R3: With level_mode=1, a high req_in sets the pending flag. The flag is re-armed one cycle after clr_pulse. A req_in that is still high in that cycle starts a new move, with its read strobe 7 cycles after the previous one. A req_in that falls at most 3 cycles after the write strobe starts nothing.
- R4: While a request is pending and desc_sel=0, irq_out is 1 and no bus strobe is issued. An int_ack given while the engine is idle clears the request, and irq_out is 0 on the next cycle.
- R5: With direction 0, the engine drives bus_rd for one cycle at the peripheral address, 2 cycles after the pending flag is set. In the next cycle it drives bus_wr at the buffer address, with bus_wdata equal to the data it read.
- R6: With direction 1, the read strobe goes to the buffer address and the following write strobe goes to the peripheral address. The timing and the data path are the same as in R5.
- R7: Only bits 7:0 of dl_io_ptr are stored. Every peripheral access drives bus_addr with bits 23:8 equal to zero.
- R8: Two cycles after the write strobe, clr_pulse is 1 for one cycle. In that cycle desc_buf has gone up by 1 and desc_count has gone down by 1. The pending flag is clear on the following cycle.
- R9: When a move brings desc_count to 0, desc_sel becomes 0 and eot_irq becomes 1 in the same cycle. The next request raises irq_out. An int_ack given while the engine is idle clears eot_irq.
- R10: A request accepted with desc_sel=1 and desc_count=0 issues no bus strobe. One cycle after acceptance it clears desc_sel, sets eot_irq and pulses clr_pulse.
- R11: A descriptor load given while a move is in progress has no effect on the descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_in | input | 1 | External request pin |
| level_mode | input | 1 | 1: high level sets the request; 0: rising edge sets it |
| int_ack | input | 1 | Interrupt acknowledge from software, taken while idle |
| dl_we | input | 1 | Descriptor load strobe |
| dl_io_ptr | input | 24 | Peripheral pointer; only bits 7:0 are kept |
| dl_buf_ptr | input | 24 | Buffer start address |
| dl_count | input | 8 | Number of items to move |
| dl_dir | input | 1 | 0: peripheral to memory; 1: memory to peripheral |
| dl_sel | input | 1 | 1: move data on request; 0: plain interrupt |
| bus_addr | output | 24 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled in the read cycle |
| clr_pulse | output | 1 | One-cycle clear of the pending flag after a move |
| irq_out | output | 1 | Plain interrupt request |
| eot_irq | output | 1 | End-of-transfer interrupt |
| desc_buf | output | 24 | Current buffer pointer |
| desc_count | output | 8 | Remaining item count |
| desc_sel | output | 1 | Current select bit |

## Verification
Some properties are checked by assertions on every cycle. The read and write strobes never overlap, and every read is followed by a write. Peripheral addresses carry zero upper bits. The clear pulse always lands two cycles after a write, and the count drops by exactly one per move. The pending flag stays set until a clear and is gone right after one. An interrupt never coincides with a bus strobe, and end-of-transfer always turns the select bit off. Other behaviour can only be shown by the bench's scenarios. These are the actual addresses and data for each direction, edges ignored while a request is pending, and the level re-trigger against a request dropped inside the window. They also cover the zero-count shortcut and the refusal of a descriptor load during a move.

// File: rtl/dxe_pkg.sv
package dxe_pkg;

    localparam int IO_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_READ,
        ST_XFER_RD,
        ST_XFER_WR,
        ST_DESC_UPDATE,
        ST_CLEAR
    } seq_state_e;

endpackage

// File: rtl/dxe_req_latch.sv
module dxe_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic level_mode_i,
    input  logic clr_i,
    output logic pending_o
);

    typedef struct packed {
        logic req_prev;
        logic cause;
    } latch_t;

    latch_t d, q;
    logic   set_req;

    always_comb begin
        d          = q;
        d.req_prev = req_i;
        set_req    = level_mode_i ? req_i : (req_i & ~q.req_prev);
        if (clr_i) begin
            d.cause = 1'b0;
        end else if (set_req) begin
            d.cause = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pending_o = q.cause;

    // R8: a clear request always drops the pending flag
    a_r8_clear_drops_pending: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !q.cause);

    // R2: once set, the flag holds until a clear arrives
    a_r2_pending_holds: assert property (@(posedge clk) disable iff (rst)
        (q.cause && !clr_i) |=> q.cause);

endmodule

// File: rtl/dxe_addr_mux.sv
module dxe_addr_mux #(
    parameter int ADDR_W = 24,
    parameter int IO_W   = 8
) (
    input  logic [IO_W-1:0]   io_ptr_i,
    input  logic [ADDR_W-1:0] buf_ptr_i,
    input  logic              dir_i,
    input  logic              wr_phase_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int PAD_W = ADDR_W - IO_W;

    logic io_side;

    always_comb begin
        io_side = dir_i ? wr_phase_i : ~wr_phase_i;
        addr_o  = io_side ? {{PAD_W{1'b0}}, io_ptr_i} : buf_ptr_i;
    end

endmodule

// File: rtl/dxe_sequencer.sv
module dxe_sequencer
    import dxe_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pending_i,
    input  logic              int_ack_i,
    input  logic              dl_we_i,
    input  logic [ADDR_W-1:0] dl_io_ptr_i,
    input  logic [ADDR_W-1:0] dl_buf_ptr_i,
    input  logic [CNT_W-1:0]  dl_count_i,
    input  logic              dl_dir_i,
    input  logic              dl_sel_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_rd_o,
    output logic              bus_wr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    output logic              xfer_clr_o,
    output logic              ack_clr_o,
    output logic              irq_o,
    output logic              eot_irq_o,
    output logic [ADDR_W-1:0] desc_buf_o,
    output logic [CNT_W-1:0]  desc_count_o,
    output logic              desc_sel_o
);

    typedef struct packed {
        seq_state_e        state;
        logic [IO_W-1:0]   io_ptr;
        logic [ADDR_W-1:0] buf_ptr;
        logic [CNT_W-1:0]  count;
        logic              dir;
        logic              sel;
        logic              eot;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t d, q;

    always_comb begin
        d          = q;
        bus_rd_o   = 1'b0;
        bus_wr_o   = 1'b0;
        xfer_clr_o = 1'b0;
        ack_clr_o  = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (dl_we_i) begin
                    d.io_ptr  = dl_io_ptr_i[IO_W-1:0];
                    d.buf_ptr = dl_buf_ptr_i;
                    d.count   = dl_count_i;
                    d.dir     = dl_dir_i;
                    d.sel     = dl_sel_i;
                end
                if (pending_i && q.sel) begin
                    d.state = ST_DESC_READ;
                end else if (int_ack_i) begin
                    d.eot     = 1'b0;
                    ack_clr_o = pending_i;
                end
            end
            ST_DESC_READ: begin
                if (q.count == '0) begin
                    d.sel   = 1'b0;
                    d.eot   = 1'b1;
                    d.state = ST_CLEAR;
                end else begin
                    d.state = ST_XFER_RD;
                end
            end
            ST_XFER_RD: begin
                bus_rd_o = 1'b1;
                d.data   = bus_rdata_i;
                d.state  = ST_XFER_WR;
            end
            ST_XFER_WR: begin
                bus_wr_o = 1'b1;
                d.state  = ST_DESC_UPDATE;
            end
            ST_DESC_UPDATE: begin
                d.buf_ptr = q.buf_ptr + ADDR_W'(1);
                d.count   = q.count - CNT_W'(1);
                if (q.count == CNT_W'(1)) begin
                    d.sel = 1'b0;
                    d.eot = 1'b1;
                end
                d.state = ST_CLEAR;
            end
            ST_CLEAR: begin
                xfer_clr_o = 1'b1;
                d.state    = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    dxe_addr_mux #(
        .ADDR_W (ADDR_W),
        .IO_W   (IO_W)
    ) i_addr_mux (
        .io_ptr_i   (q.io_ptr),
        .buf_ptr_i  (q.buf_ptr),
        .dir_i      (q.dir),
        .wr_phase_i (q.state == ST_XFER_WR),
        .addr_o     (bus_addr_o)
    );

    assign bus_wdata_o  = q.data;
    assign irq_o        = pending_i && !q.sel && (q.state == ST_IDLE);
    assign eot_irq_o    = q.eot;
    assign desc_buf_o   = q.buf_ptr;
    assign desc_count_o = q.count;
    assign desc_sel_o   = q.sel;

    // R5: strobes never overlap
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_rd_o, bus_wr_o}));

    // R5: each read strobe is followed by a write strobe
    a_r5_rd_then_wr: assert property (@(posedge clk) disable iff (rst)
        bus_rd_o |=> bus_wr_o);

    // R7: peripheral side accesses use a zero upper address
    a_r7_io_upper_zero: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd_o && !q.dir) || (bus_wr_o && q.dir)) |-> (bus_addr_o[ADDR_W-1:IO_W] == '0));

    // R8: clear pulse two cycles after the write strobe
    a_r8_clear_after_write: assert property (@(posedge clk) disable iff (rst)
        bus_wr_o |-> ##2 xfer_clr_o);

    // R8: one item consumed per move
    a_r8_count_step: assert property (@(posedge clk) disable iff (rst)
        (xfer_clr_o && $past(bus_wr_o, 2)) |-> (q.count == $past(q.count, 2) - CNT_W'(1)));

    // R9: end of transfer always leaves the select bit off
    a_r9_eot_clears_sel: assert property (@(posedge clk) disable iff (rst)
        $rose(q.eot) |-> !q.sel);

    // R4: a plain interrupt never coincides with a bus strobe
    a_r4_irq_no_strobe: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (!bus_rd_o && !bus_wr_o));

endmodule

// File: rtl/desc_xfer_engine.sv
module desc_xfer_engine #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_in,
    input  logic              level_mode,
    input  logic              int_ack,
    input  logic              dl_we,
    input  logic [ADDR_W-1:0] dl_io_ptr,
    input  logic [ADDR_W-1:0] dl_buf_ptr,
    input  logic [CNT_W-1:0]  dl_count,
    input  logic              dl_dir,
    input  logic              dl_sel,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              clr_pulse,
    output logic              irq_out,
    output logic              eot_irq,
    output logic [ADDR_W-1:0] desc_buf,
    output logic [CNT_W-1:0]  desc_count,
    output logic              desc_sel
);

    logic pending;
    logic xfer_clr;
    logic ack_clr;

    dxe_req_latch i_req_latch (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req_in),
        .level_mode_i (level_mode),
        .clr_i        (xfer_clr | ack_clr),
        .pending_o    (pending)
    );

    dxe_sequencer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) i_sequencer (
        .clk          (clk),
        .rst          (rst),
        .pending_i    (pending),
        .int_ack_i    (int_ack),
        .dl_we_i      (dl_we),
        .dl_io_ptr_i  (dl_io_ptr),
        .dl_buf_ptr_i (dl_buf_ptr),
        .dl_count_i   (dl_count),
        .dl_dir_i     (dl_dir),
        .dl_sel_i     (dl_sel),
        .bus_addr_o   (bus_addr),
        .bus_rd_o     (bus_rd),
        .bus_wr_o     (bus_wr),
        .bus_wdata_o  (bus_wdata),
        .bus_rdata_i  (bus_rdata),
        .xfer_clr_o   (xfer_clr),
        .ack_clr_o    (ack_clr),
        .irq_o        (irq_out),
        .eot_irq_o    (eot_irq),
        .desc_buf_o   (desc_buf),
        .desc_count_o (desc_count),
        .desc_sel_o   (desc_sel)
    );

    assign clr_pulse = xfer_clr;

endmodule

// File: tb/test_desc_xfer_engine.sv
`timescale 1ns/1ps
module test_desc_xfer_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_in = 1'b0;
    logic        level_mode = 1'b0;
    logic        int_ack = 1'b0;
    logic        dl_we = 1'b0;
    logic [23:0] dl_io_ptr = '0;
    logic [23:0] dl_buf_ptr = '0;
    logic [7:0]  dl_count = '0;
    logic        dl_dir = 1'b0;
    logic        dl_sel = 1'b0;
    logic [23:0] bus_addr;
    logic        bus_rd;
    logic        bus_wr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        clr_pulse;
    logic        irq_out;
    logic        eot_irq;
    logic [23:0] desc_buf;
    logic [7:0]  desc_count;
    logic        desc_sel;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    function automatic logic [15:0] peer_data(input logic [23:0] a);
        return {a[7:0], a[15:8]} ^ 16'hA5C3;
    endfunction

    assign bus_rdata = peer_data(bus_addr);

    desc_xfer_engine i_desc_xfer_engine (
        .clk        (clk),
        .rst        (rst),
        .req_in     (req_in),
        .level_mode (level_mode),
        .int_ack    (int_ack),
        .dl_we      (dl_we),
        .dl_io_ptr  (dl_io_ptr),
        .dl_buf_ptr (dl_buf_ptr),
        .dl_count   (dl_count),
        .dl_dir     (dl_dir),
        .dl_sel     (dl_sel),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .clr_pulse  (clr_pulse),
        .irq_out    (irq_out),
        .eot_irq    (eot_irq),
        .desc_buf   (desc_buf),
        .desc_count (desc_count),
        .desc_sel   (desc_sel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic load(input logic [23:0] io, input logic [23:0] bp,
                        input logic [7:0] cnt, input logic dir, input logic sel);
        dl_we = 1'b1; dl_io_ptr = io; dl_buf_ptr = bp;
        dl_count = cnt; dl_dir = dir; dl_sel = sel;
        tick();
        dl_we = 1'b0;
    endtask

    task automatic ack();
        int_ack = 1'b1;
        tick();
        int_ack = 1'b0;
    endtask

    // one edge-triggered move; descriptor already loaded
    task automatic run_one(input logic dir, input logic [23:0] io,
                           input logic [23:0] bp, input logic [7:0] cnt);
        logic [23:0] io_a, src, dst;
        io_a = {16'h0, io[7:0]};
        src  = dir ? bp : io_a;
        dst  = dir ? io_a : bp;
        req_in = 1'b1;
        tick();
        req_in = 1'b0;
        tick(2);
        chk(dir ? "R6 rd strobe" : "R5 rd strobe", {31'd0, bus_rd}, 1);
        chk("R7 rd addr", bus_addr, src);
        tick();
        chk(dir ? "R6 wr strobe" : "R5 wr strobe", {31'd0, bus_wr}, 1);
        chk("R7 wr addr", bus_addr, dst);
        chk(dir ? "R6 wr data" : "R5 wr data", bus_wdata, peer_data(src));
        tick(2);
        chk("R8 clr pulse", {31'd0, clr_pulse}, 1);
        chk("R8 buf step", desc_buf, bp + 24'd1);
        chk("R8 count step", desc_count, cnt - 8'd1);
        chk("R9 eot", {31'd0, eot_irq}, (cnt == 8'd1) ? 1 : 0);
        chk("R9 sel", {31'd0, desc_sel}, (cnt == 8'd1) ? 0 : 1);
        tick();
        chk("R8 clr one cycle", {31'd0, clr_pulse}, 0);
        chk("R8 idle no strobe", {30'd0, bus_rd, bus_wr}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        tick(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 irq", {31'd0, irq_out}, 0);
        chk("R1 eot", {31'd0, eot_irq}, 0);
        chk("R1 strobes", {30'd0, bus_rd, bus_wr}, 0);
        chk("R1 clr", {31'd0, clr_pulse}, 0);
        chk("R1 sel", {31'd0, desc_sel}, 0);

        // R4 / R2: plain interrupt, edges ignored while pending
        load(24'h000010, 24'h001000, 8'd4, 1'b0, 1'b0);
        req_in = 1'b1; tick();
        chk("R4 irq raised", {31'd0, irq_out}, 1);
        req_in = 1'b0; tick();
        req_in = 1'b1; tick();
        req_in = 1'b0; tick();
        chk("R4 no strobe", {30'd0, bus_rd, bus_wr}, 0);
        chk("R4 irq held", {31'd0, irq_out}, 1);
        ack();
        chk("R4 irq cleared", {31'd0, irq_out}, 0);
        tick(2);
        chk("R2 extra edge ignored", {31'd0, irq_out}, 0);

        // R5 / R7 directed, upper pointer bits junk
        load(24'hAB1234, 24'h004000, 8'd2, 1'b0, 1'b1);
        run_one(1'b0, 24'hAB1234, 24'h004000, 8'd2);
        // R6 directed
        load(24'h0000F0, 24'h005500, 8'd3, 1'b1, 1'b1);
        run_one(1'b1, 24'h0000F0, 24'h005500, 8'd3);

        // R9: last item ends the service, next request is plain interrupt
        load(24'h000022, 24'h006000, 8'd1, 1'b0, 1'b1);
        run_one(1'b0, 24'h000022, 24'h006000, 8'd1);
        req_in = 1'b1; tick();
        req_in = 1'b0;
        chk("R9 plain irq after end", {31'd0, irq_out}, 1);
        tick(2);
        chk("R9 no move after end", {30'd0, bus_rd, bus_wr}, 0);
        ack();
        chk("R9 eot cleared", {31'd0, eot_irq}, 0);
        chk("R9 irq cleared", {31'd0, irq_out}, 0);

        // R10: zero count on acceptance
        load(24'h000030, 24'h007000, 8'd0, 1'b0, 1'b1);
        req_in = 1'b1; tick();
        req_in = 1'b0; tick();
        chk("R10 no strobe", {30'd0, bus_rd, bus_wr}, 0);
        tick();
        chk("R10 clr", {31'd0, clr_pulse}, 1);
        chk("R10 no strobe 2", {30'd0, bus_rd, bus_wr}, 0);
        chk("R10 eot", {31'd0, eot_irq}, 1);
        chk("R10 sel off", {31'd0, desc_sel}, 0);
        tick();
        chk("R10 no irq", {31'd0, irq_out}, 0);
        ack();

        // R3: level held re-triggers, level dropped in window does not
        level_mode = 1'b1;
        load(24'h000044, 24'h008000, 8'd3, 1'b0, 1'b1);
        req_in = 1'b1;
        tick(3);
        chk("R3 first rd", {31'd0, bus_rd}, 1);
        tick(7);
        chk("R3 retrigger rd", {31'd0, bus_rd}, 1);
        chk("R3 retrigger addr", bus_addr, 24'h000044);
        tick(2);
        req_in = 1'b0;
        tick(5);
        chk("R3 no retrigger", {30'd0, bus_rd, bus_wr}, 0);
        chk("R3 count", desc_count, 8'd1);
        level_mode = 1'b0;

        // R11: load during a move is ignored
        load(24'h000050, 24'h009000, 8'd5, 1'b1, 1'b1);
        req_in = 1'b1; tick();
        req_in = 1'b0; tick(2);
        dl_we = 1'b1; dl_buf_ptr = 24'h999999; dl_count = 8'd77; dl_sel = 1'b0;
        tick();
        dl_we = 1'b0;
        tick(2);
        chk("R11 buf kept", desc_buf, 24'h009001);
        chk("R11 count kept", desc_count, 8'd4);
        chk("R11 sel kept", {31'd0, desc_sel}, 1);
        tick();

        // random moves (R5, R6, R7, R8, R9)
        for (int k = 0; k < 24; k++) begin
            logic        dir;
            logic [23:0] io, bp;
            logic [7:0]  cnt;
            dir = 1'($urandom_range(0, 1));
            io  = 24'($urandom);
            bp  = 24'($urandom_range(24'h000100, 24'hFFF000));
            cnt = 8'($urandom_range(1, 4));
            load(io, bp, cnt, dir, 1'b1);
            run_one(dir, io, bp, cnt);
            if (cnt == 8'd1) ack();
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule